// File: doc/BRIEF.md
# Home Node Error Reporter

This block sits on the data-response path of a cache home node. Each cycle it may receive one response event, tagged with where the data came from: a memory read, a snoop response from a requesting cache, or an eviction from the local L3. The event also carries the ECC result for its data and the response-error field it already holds. The block forwards the response one cycle later, with the response-error field filled in. It also decides whether this node itself must tell the central management node about an error.

Reporting follows a first-detector policy. Data that arrives already marked bad, or that is only passing through on its way to a requester or to memory, is forwarded quietly. Two things raise a management-node pulse. The first is an uncorrectable error that this node finds on its own eviction data. The second is a correctable-error count that reaches a programmable threshold. Correctable errors found on eviction data are counted in a saturating counter. Software can read this counter and clear it.

Top module: `hn_err_report`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `mn_pulse` are 0, `mn_cause` is 00 and `corr_count` is 0.
- R2: A response sampled with `in_valid` high appears on `out_valid` and `out_resp` one clock later. The response-error codes are 00 okay, 10 data error and 11 non-data error. An incoming non-okay `in_resp` is forwarded unchanged.
- R3: Memory data (origin 00) or snoop data (origin 01) with ECC code 10 (uncorrectable) and an okay `in_resp` is forwarded as 10. It raises no management pulse and leaves the count unchanged.
- R4: Eviction data (origin 10) with ECC code 10 produces `mn_pulse` with `mn_cause` 01 one clock after it is sampled.
- R5: Eviction data with ECC code 01 (correctable) adds one to `corr_count` on the next clock and raises no pulse by itself. ECC code 01 on memory or snoop data leaves the count unchanged.
- R6: When an increment makes `corr_count` equal to a non-zero `cnt_thresh`, a pulse with `mn_cause` 10 follows one clock after the count update. A threshold of 0 never fires.
- R7: The count stops at its maximum value and does not wrap.
- R8: A high `cnt_clear` sets the count to 0 on the next clock, even when an increment is present in the same cycle.
- R9: If an eviction pulse and a threshold pulse fall due in the same cycle, the eviction pulse is sent first and the threshold pulse is sent on the following cycle.
- R10: `mn_cause` is 00 whenever `mn_pulse` is low and is 01 or 10 whenever it is high. Each event produces exactly one pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Response event present this cycle |
| in_origin | input | 2 | 00 memory, 01 snoop, 10 eviction |
| in_ecc | input | 2 | 00 clean, 01 correctable, 10 uncorrectable |
| in_resp | input | 2 | Response-error field as received |
| cnt_thresh | input | CNT_W | Correctable-error threshold (0 disables) |
| cnt_clear | input | 1 | Write-one-to-clear pulse for the count |
| out_valid | output | 1 | Forwarded response valid |
| out_resp | output | 2 | Forwarded response-error field |
| mn_pulse | output | 1 | One-cycle error signal to the management node |
| mn_cause | output | 2 | 01 eviction uncorrectable, 10 threshold reached |
| corr_count | output | CNT_W | Correctable-error count |

## Verification
A corrupted count is visible on `corr_count` on the clock after the bad update. It also shifts the threshold pulse: the pulse is missed, comes too early, or comes twice. A lost or stuck pending flag appears within one cycle of an eviction collision, as a missing or repeated cause-10 pulse. A wrong forwarding decision shows on `out_resp` one clock after the event. The bench models these rules cycle by cycle and compares `mn_pulse`, `mn_cause` and `corr_count` on every cycle. It compares forwarded responses against a queue of expected items.

// File: rtl/hn_err_pkg.sv
package hn_err_pkg;

    typedef enum logic [1:0] {
        ORG_MEM   = 2'b00,
        ORG_SNP   = 2'b01,
        ORG_EVICT = 2'b10,
        ORG_RSVD  = 2'b11
    } origin_e;

    typedef enum logic [1:0] {
        ECC_NONE   = 2'b00,
        ECC_CORR   = 2'b01,
        ECC_UNCORR = 2'b10,
        ECC_RSVD   = 2'b11
    } ecc_e;

    typedef enum logic [1:0] {
        RSP_OKAY        = 2'b00,
        RSP_RSVD        = 2'b01,
        RSP_DATA_ERR    = 2'b10,
        RSP_NONDATA_ERR = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'b00,
        CAUSE_EVICT_UE  = 2'b01,
        CAUSE_CE_THRESH = 2'b10,
        CAUSE_RSVD      = 2'b11
    } cause_e;

    typedef struct packed {
        logic    valid;
        origin_e origin;
        ecc_e    ecc;
        resp_e   resp;
    } rsp_evt_t;

    // An error already marked by an earlier detector wins; otherwise mark local uncorrectable data.
    function automatic resp_e fwd_resp(rsp_evt_t e);
        if (e.resp != RSP_OKAY)
            return e.resp;
        if (e.ecc == ECC_UNCORR)
            return RSP_DATA_ERR;
        return RSP_OKAY;
    endfunction

    function automatic logic is_evict_ue(rsp_evt_t e);
        return e.valid && (e.origin == ORG_EVICT) && (e.ecc == ECC_UNCORR);
    endfunction

    function automatic logic is_evict_ce(rsp_evt_t e);
        return e.valid && (e.origin == ORG_EVICT) && (e.ecc == ECC_CORR);
    endfunction

endpackage

// File: rtl/hn_resp_fwd.sv
module hn_resp_fwd
    import hn_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rsp_evt_t evt,
    output logic     out_valid,
    output resp_e    out_resp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_resp  <= RSP_OKAY;
        end else begin
            out_valid <= evt.valid;
            out_resp  <= evt.valid ? fwd_resp(evt) : RSP_OKAY;
        end
    end

    AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> out_valid); // R2

    AST_MARKED_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.resp != RSP_OKAY) |=> (out_resp == $past(evt.resp))); // R2

    AST_UE_TO_DERR: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.resp == RSP_OKAY && evt.ecc == ECC_UNCORR)
        |=> (out_valid && out_resp == RSP_DATA_ERR)); // R3

endmodule

// File: rtl/hn_corr_counter.sv
module hn_corr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             thr_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;

    always_comb begin
        cnt_nxt = count;
        hit     = 1'b0;
        if (clr) begin
            cnt_nxt = '0;
        end else if (inc && count != CNT_MAX) begin
            cnt_nxt = count + 1'b1;
            hit     = (thresh != '0) && (cnt_nxt == thresh);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            thr_evt <= 1'b0;
        end else begin
            count   <= cnt_nxt;
            thr_evt <= hit;
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX)); // R7

    AST_CLR_PRIO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(count)); // R5

    AST_THR_ONCE: assert property (@(posedge clk) disable iff (rst)
        thr_evt |=> !thr_evt); // R6

endmodule

// File: rtl/hn_mn_report.sv
module hn_mn_report
    import hn_err_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   evict_ue,
    input  logic   thr_evt,
    output logic   mn_pulse,
    output cause_e mn_cause
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mn_pulse <= 1'b0;
            mn_cause <= CAUSE_NONE;
            pend     <= 1'b0;
        end else if (evict_ue) begin
            mn_pulse <= 1'b1;
            mn_cause <= CAUSE_EVICT_UE;
            pend     <= pend | thr_evt;
        end else if (thr_evt || pend) begin
            mn_pulse <= 1'b1;
            mn_cause <= CAUSE_CE_THRESH;
            pend     <= 1'b0;
        end else begin
            mn_pulse <= 1'b0;
            mn_cause <= CAUSE_NONE;
        end
    end

    AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (rst)
        evict_ue |=> (mn_pulse && mn_cause == CAUSE_EVICT_UE)); // R4

    AST_DEFER_THRESH: assert property (@(posedge clk) disable iff (rst)
        (evict_ue && thr_evt) ##1 !evict_ue |=> (mn_pulse && mn_cause == CAUSE_CE_THRESH)); // R9

    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mn_pulse |-> (mn_cause == CAUSE_NONE)); // R10

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mn_pulse |-> (mn_cause == CAUSE_EVICT_UE || mn_cause == CAUSE_CE_THRESH)); // R10

endmodule

// File: rtl/hn_err_report.sv
module hn_err_report
    import hn_err_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_origin,
    input  logic [1:0]       in_ecc,
    input  logic [1:0]       in_resp,
    input  logic [CNT_W-1:0] cnt_thresh,
    input  logic             cnt_clear,
    output logic             out_valid,
    output logic [1:0]       out_resp,
    output logic             mn_pulse,
    output logic [1:0]       mn_cause,
    output logic [CNT_W-1:0] corr_count
);

    rsp_evt_t evt;
    resp_e    fwd_code;
    cause_e   cause;
    logic     thr_evt;

    always_comb begin
        evt.valid  = in_valid;
        evt.origin = origin_e'(in_origin);
        evt.ecc    = ecc_e'(in_ecc);
        evt.resp   = resp_e'(in_resp);
    end

    hn_resp_fwd u_fwd (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .out_valid (out_valid),
        .out_resp  (fwd_code)
    );

    hn_corr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (is_evict_ce(evt)),
        .clr     (cnt_clear),
        .thresh  (cnt_thresh),
        .count   (corr_count),
        .thr_evt (thr_evt)
    );

    hn_mn_report u_rpt (
        .clk      (clk),
        .rst      (rst),
        .evict_ue (is_evict_ue(evt)),
        .thr_evt  (thr_evt),
        .mn_pulse (mn_pulse),
        .mn_cause (cause)
    );

    assign out_resp = fwd_code;
    assign mn_cause = cause;

    AST_PASSTHRU_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_origin != 2'b10 && !thr_evt) |=> (mn_cause != CAUSE_EVICT_UE)); // R3

endmodule

// File: tb/tb_hn_err_report.sv
module tb_hn_err_report;

    localparam int CW  = 8;
    localparam int MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_origin = 2'b00;
    logic [1:0]    in_ecc = 2'b00;
    logic [1:0]    in_resp = 2'b00;
    logic [CW-1:0] cnt_thresh = '0;
    logic          cnt_clear = 1'b0;
    logic          out_valid;
    logic [1:0]    out_resp;
    logic          mn_pulse;
    logic [1:0]    mn_cause;
    logic [CW-1:0] corr_count;

    always #5 clk = ~clk;

    hn_err_report #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_origin(in_origin),
        .in_ecc(in_ecc), .in_resp(in_resp), .cnt_thresh(cnt_thresh),
        .cnt_clear(cnt_clear), .out_valid(out_valid), .out_resp(out_resp),
        .mn_pulse(mn_pulse), .mn_cause(mn_cause), .corr_count(corr_count)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string phase = "R1";
    logic [1:0] fwd_q[$];

    // Requirement model, advanced on each clock edge
    int         m_cnt = 0;
    bit         m_thr = 0, m_pend = 0, m_pulse = 0;
    logic [1:0] m_cause = 2'b00;

    always @(posedge clk) begin
        bit ev, inc, tn;
        ev  = in_valid && in_origin == 2'b10 && in_ecc == 2'b10;
        inc = in_valid && in_origin == 2'b10 && in_ecc == 2'b01;
        if (rst) begin
            m_cnt = 0; m_thr = 0; m_pend = 0; m_pulse = 0; m_cause = 2'b00;
        end else begin
            if (ev) begin
                m_pulse = 1; m_cause = 2'b01; m_pend = m_pend | m_thr;
            end else if (m_thr || m_pend) begin
                m_pulse = 1; m_cause = 2'b10; m_pend = 0;
            end else begin
                m_pulse = 0; m_cause = 2'b00;
            end
            tn = 0;
            if (cnt_clear) m_cnt = 0;
            else if (inc && m_cnt != MAX) begin
                m_cnt++;
                if (cnt_thresh != 0 && m_cnt == int'(cnt_thresh)) tn = 1;
            end
            m_thr = tn;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard and compares per cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk(phase, "mn_pulse", int'(mn_pulse), int'(m_pulse));
            chk(phase, "mn_cause", int'(mn_cause), int'(m_cause));
            chk(phase, "corr_count", int'(corr_count), m_cnt);
            if (out_valid) begin
                if (fwd_q.size() == 0) chk(phase, "unexpected out_valid", 1, 0);
                else begin
                    logic [1:0] e;
                    e = fwd_q.pop_front();
                    chk(phase, "out_resp", int'(out_resp), int'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=%0d expected=finish", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [1:0] o, input logic [1:0] e, input logic [1:0] r, input bit clr = 0);
        @(negedge clk);
        in_valid = 1'b1; in_origin = o; in_ecc = e; in_resp = r; cnt_clear = clr;
        fwd_q.push_back(r != 2'b00 ? r : (e == 2'b10 ? 2'b10 : 2'b00));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; cnt_clear = 1'b0;
        end
    endtask

    task automatic clear_cnt();
        @(negedge clk);
        in_valid = 1'b0; cnt_clear = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset mn_pulse", int'(mn_pulse), 0);
        chk("R1", "reset mn_cause", int'(mn_cause), 0);
        chk("R1", "reset corr_count", int'(corr_count), 0);
        rst = 1'b0;
        cnt_thresh = 8'd3;
        idle(1);

        phase = "R2";
        send(2'b00, 2'b00, 2'b00);
        send(2'b00, 2'b00, 2'b10);
        send(2'b00, 2'b10, 2'b11);
        send(2'b01, 2'b00, 2'b11);
        idle(2);

        phase = "R3";
        send(2'b00, 2'b10, 2'b00);
        send(2'b01, 2'b10, 2'b00);
        idle(2);

        phase = "R4";
        send(2'b10, 2'b10, 2'b00);
        idle(2);

        phase = "R5";
        send(2'b00, 2'b01, 2'b00);
        send(2'b01, 2'b01, 2'b00);
        send(2'b10, 2'b01, 2'b00);
        send(2'b10, 2'b01, 2'b00);
        idle(3);

        phase = "R6";
        send(2'b10, 2'b01, 2'b00);
        idle(3);
        send(2'b10, 2'b01, 2'b00);
        idle(3);

        phase = "R8";
        send(2'b10, 2'b01, 2'b00, 1);
        idle(2);

        phase = "R9";
        cnt_thresh = 8'd2;
        send(2'b10, 2'b01, 2'b00);
        send(2'b10, 2'b01, 2'b00);
        send(2'b10, 2'b10, 2'b00);
        idle(4);

        phase = "R10";
        clear_cnt();
        send(2'b10, 2'b01, 2'b00);
        send(2'b10, 2'b01, 2'b00);
        idle(1);
        send(2'b10, 2'b10, 2'b00);
        idle(4);

        phase = "R6";
        clear_cnt();
        idle(1);
        cnt_thresh = 8'd0;
        repeat (5) send(2'b10, 2'b01, 2'b00);
        idle(3);

        phase = "R7";
        clear_cnt();
        idle(1);
        cnt_thresh = 8'd250;
        repeat (MAX + 6) send(2'b10, 2'b01, 2'b00);
        idle(3);
        @(negedge clk);
        chk("R7", "saturated count", int'(corr_count), MAX);

        phase = "R8";
        clear_cnt();
        idle(2);
        chk("R8", "cleared count", int'(corr_count), 0);
        chk("R2", "scoreboard drained", fwd_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule